// File: doc/BRIEF.md
# Read/Write Request Arbiter

This block sits between two request queues, one for reads and one for writes, and a single downstream access port. Requests arrive on valid/ready handshakes and wait in one queue per type. A small state machine takes one request at a time from the queue heads and presents it on a grant handshake. It then waits for a completion pulse before it starts the next access. A 2-bit policy input chooses between strict read priority, strict write priority and round-robin alternation, and it can change while the block runs.

Each queue asserts backpressure once its occupancy reaches a programmable watermark. An enable input gates traffic. While it is low, requests are accepted and thrown away, completions are swallowed and no new access starts. A synchronous soft reset empties both queues and returns the controller to idle. A busy output shows that work is still pending.

The state machine has three states. IDLE waits for an entry. On the *start* transition (enable high and a queue not empty) it pops the chosen head into the grant register and moves to ISSUE. ISSUE drives the grant until the *accept* transition (grant valid and ready), which moves to WAIT. WAIT stays there until the *retire* transition (completion pulse) returns it to IDLE. Soft reset takes every state to IDLE.

Top module: `rw_arbiter`

## Requirements
- R1: With policy code 2'b10, a read is granted whenever the read queue is non-empty at selection, even if writes are also waiting.
- R2: With policy code 2'b01, a write is granted whenever the write queue is non-empty at selection.
- R3: With policy code 2'b00 or 2'b11, a tie goes to the type not chosen at the last tie, and reads win the first tie after reset. Two reads and two writes queued together are granted read, write, read, write.
- R4: In round-robin mode, a selection made while only one queue is non-empty leaves the tie pointer unchanged.
- R5: While enable is 0, rd_ready and wr_ready are 1, accepted requests are discarded and never granted, and no new access starts. An access already in ISSUE still completes its handshake.
- R6: cpl_out equals cpl_in while enable is 1 and is 0 while enable is 0. A completion in WAIT retires the access in either case.
- R7: A queue's input ready is 0 while enable is 1 and its occupancy is at least the watermark (or the queue is at capacity). The two queues apply backpressure independently.
- R8: busy is 1 while either queue holds an entry or the controller is in ISSUE or WAIT, and 0 otherwise.
- R9: A soft reset pulse empties both queues, drops any in-flight access, returns to IDLE and clears the tie pointer.
- R10: gnt_valid, gnt_write and gnt_data stay stable until gnt_ready. After acceptance, no new grant appears until a completion is received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Synchronous clear of queues, controller and tie pointer |
| enable | input | 1 | Traffic gate; 0 drops requests and completions |
| mode | input | 2 | Policy: 10 read first, 01 write first, 00/11 round-robin |
| watermark | input | WMW (5) | Queue occupancy at which input ready drops |
| rd_valid | input | 1 | Read request valid |
| rd_ready | output | 1 | Read request ready |
| rd_data | input | DW (8) | Read request payload |
| wr_valid | input | 1 | Write request valid |
| wr_ready | output | 1 | Write request ready |
| wr_data | input | DW (8) | Write request payload |
| gnt_valid | output | 1 | Grant valid toward the access port |
| gnt_ready | input | 1 | Access port accepts the grant |
| gnt_write | output | 1 | 1 when the granted access is a write |
| gnt_data | output | DW (8) | Payload of the granted access |
| cpl_in | input | 1 | Completion pulse from the access port |
| cpl_out | output | 1 | Completion passed upstream while enabled |
| busy | output | 1 | Work pending or in flight |

## Verification
The bench uses the default build: queue depth 8, 5-bit watermark and 8-bit payload. Depth 8 is above the watermark of 3 used for the backpressure case, so the watermark stops the queue before capacity does. With watermark 3 the read queue saturates after four pushes: one entry goes to the grant register and three stay queued. Holding the grant stalled makes that case, and disabling and re-enabling around a partly filled queue, take only a few dozen cycles.

// File: rtl/rwa_pkg.sv
package rwa_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2
    } rwa_state_e;

    localparam logic [1:0] POL_RD_FIRST = 2'b10;
    localparam logic [1:0] POL_WR_FIRST = 2'b01;

endpackage

// File: rtl/rwa_queue.sv
module rwa_queue #(
    parameter int DEPTH = 8,
    parameter int DW    = 8,
    parameter int WMW   = 5
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clr,
    input  logic [WMW-1:0] wm,
    input  logic           push,
    input  logic [DW-1:0]  din,
    input  logic           pop,
    output logic [DW-1:0]  dout,
    output logic           not_empty,
    output logic           full
);
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW   = $clog2(DEPTH + 1);
    localparam int CMPW = ((CW > WMW) ? CW : WMW) + 1;

    logic [DW-1:0] slots [DEPTH];
    logic [AW-1:0] head_q, tail_q;
    logic [CW-1:0] fill_q;

    function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign not_empty = (fill_q != '0);
    assign full      = (CMPW'(fill_q) >= CMPW'(wm)) || (fill_q == CW'(DEPTH));
    assign dout      = slots[head_q];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            head_q <= '0;
            tail_q <= '0;
            fill_q <= '0;
        end else if (clr) begin
            head_q <= '0;
            tail_q <= '0;
            fill_q <= '0;
        end else begin
            if (push) tail_q <= step(tail_q);
            if (pop)  head_q <= step(head_q);
            if (push && !pop)      fill_q <= fill_q + 1'b1;
            else if (pop && !push) fill_q <= fill_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (push) slots[tail_q] <= din;
    end

    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n || clr)
        push |-> (fill_q < CW'(DEPTH)));

    assert_push_below_mark_R7: assert property (@(posedge clk) disable iff (!rst_n || clr)
        push |-> (CMPW'(fill_q) < CMPW'(wm)));

    assert_no_underflow_R10: assert property (@(posedge clk) disable iff (!rst_n || clr)
        pop |-> not_empty);

endmodule

// File: rtl/rwa_picker.sv
module rwa_picker (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic [1:0] mode,
    input  logic       rd_pend,
    input  logic       wr_pend,
    input  logic       take,
    output logic       pick_wr
);
    import rwa_pkg::*;

    logic last_wr_q;
    logic rr_mode;
    logic tie;

    assign rr_mode = (mode != POL_RD_FIRST) && (mode != POL_WR_FIRST);
    assign tie     = rd_pend && wr_pend;

    always_comb begin
        unique case (mode)
            POL_RD_FIRST: pick_wr = !rd_pend;
            POL_WR_FIRST: pick_wr = wr_pend;
            default:      pick_wr = tie ? !last_wr_q : wr_pend;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                      last_wr_q <= 1'b1;
        else if (clr)                    last_wr_q <= 1'b1;
        else if (take && tie && rr_mode) last_wr_q <= pick_wr;
    end

    assert_ptr_hold_R4: assert property (@(posedge clk) disable iff (!rst_n || clr)
        (take && !tie) |=> $stable(last_wr_q));

    assert_tie_alternates_R3: assert property (@(posedge clk) disable iff (!rst_n || clr)
        (take && tie && rr_mode) |=> (last_wr_q == $past(pick_wr)));

endmodule

// File: rtl/rw_arbiter.sv
module rw_arbiter #(
    parameter int DEPTH = 8,
    parameter int DW    = 8,
    parameter int WMW   = 5
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           soft_rst,
    input  logic           enable,
    input  logic [1:0]     mode,
    input  logic [WMW-1:0] watermark,
    input  logic           rd_valid,
    output logic           rd_ready,
    input  logic [DW-1:0]  rd_data,
    input  logic           wr_valid,
    output logic           wr_ready,
    input  logic [DW-1:0]  wr_data,
    output logic           gnt_valid,
    input  logic           gnt_ready,
    output logic           gnt_write,
    output logic [DW-1:0]  gnt_data,
    input  logic           cpl_in,
    output logic           cpl_out,
    output logic           busy
);
    import rwa_pkg::*;

    rwa_state_e    state_q, state_d;
    logic          rd_ne, wr_ne, rd_full, wr_full;
    logic [DW-1:0] rd_head, wr_head;
    logic          pick_wr, start;
    logic          rd_push, wr_push, rd_pop, wr_pop;
    logic          g_wr_q;
    logic [DW-1:0] g_data_q;

    assign rd_ready = !enable || !rd_full;
    assign wr_ready = !enable || !wr_full;
    assign rd_push  = rd_valid && enable && !rd_full;
    assign wr_push  = wr_valid && enable && !wr_full;

    assign start  = (state_q == ST_IDLE) && enable && (rd_ne || wr_ne);
    assign rd_pop = start && !pick_wr;
    assign wr_pop = start && pick_wr;

    rwa_queue #(.DEPTH(DEPTH), .DW(DW), .WMW(WMW)) u_rdq (
        .clk(clk), .rst_n(rst_n), .clr(soft_rst), .wm(watermark),
        .push(rd_push), .din(rd_data), .pop(rd_pop),
        .dout(rd_head), .not_empty(rd_ne), .full(rd_full)
    );

    rwa_queue #(.DEPTH(DEPTH), .DW(DW), .WMW(WMW)) u_wrq (
        .clk(clk), .rst_n(rst_n), .clr(soft_rst), .wm(watermark),
        .push(wr_push), .din(wr_data), .pop(wr_pop),
        .dout(wr_head), .not_empty(wr_ne), .full(wr_full)
    );

    rwa_picker u_pick (
        .clk(clk), .rst_n(rst_n), .clr(soft_rst), .mode(mode),
        .rd_pend(rd_ne), .wr_pend(wr_ne), .take(start), .pick_wr(pick_wr)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start)     state_d = ST_ISSUE;
            ST_ISSUE: if (gnt_ready) state_d = ST_WAIT;
            ST_WAIT:  if (cpl_in)    state_d = ST_IDLE;
            default:                 state_d = ST_IDLE;
        endcase
    end

    // State and grant registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            g_wr_q   <= 1'b0;
            g_data_q <= '0;
        end else if (soft_rst) begin
            state_q  <= ST_IDLE;
            g_wr_q   <= 1'b0;
            g_data_q <= '0;
        end else begin
            state_q <= state_d;
            if (start) begin
                g_wr_q   <= pick_wr;
                g_data_q <= pick_wr ? wr_head : rd_head;
            end
        end
    end

    // Outputs
    always_comb begin
        gnt_valid = (state_q == ST_ISSUE);
        gnt_write = g_wr_q;
        gnt_data  = g_data_q;
        cpl_out   = cpl_in && enable;
        busy      = (state_q != ST_IDLE) || rd_ne || wr_ne;
    end

    assert_read_first_R1: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
        (start && mode == POL_RD_FIRST && rd_ne) |=> (gnt_valid && !gnt_write));

    assert_write_first_R2: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
        (start && mode == POL_WR_FIRST && wr_ne) |=> (gnt_valid && gnt_write));

    assert_drop_ready_R5: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
        !enable |-> (rd_ready && wr_ready));

    assert_no_start_disabled_R5: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
        (!gnt_valid && !enable) |=> !gnt_valid);

    assert_grant_busy_R8: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
        gnt_valid |-> busy);

    assert_grant_stable_R10: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
        (gnt_valid && !gnt_ready) |=> (gnt_valid && $stable(gnt_write) && $stable(gnt_data)));

    assert_one_outstanding_R10: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
        (gnt_valid && gnt_ready) |=> !gnt_valid);

endmodule

// File: tb/rw_arbiter_bench.sv
module rw_arbiter_bench;
    localparam int DW  = 8;
    localparam int WMW = 5;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           soft_rst = 1'b0;
    logic           enable = 1'b0;
    logic [1:0]     mode = 2'b00;
    logic [WMW-1:0] watermark = 5'd8;
    logic           rd_valid = 1'b0, wr_valid = 1'b0;
    logic [DW-1:0]  rd_data = '0, wr_data = '0;
    logic           rd_ready, wr_ready;
    logic           gnt_valid, gnt_write;
    logic           gnt_ready = 1'b0;
    logic [DW-1:0]  gnt_data;
    logic           cpl_in = 1'b0;
    logic           cpl_out, busy;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    rw_arbiter #(.DEPTH(8), .DW(DW), .WMW(WMW)) u_rw_arbiter (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .enable(enable),
        .mode(mode), .watermark(watermark),
        .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
        .gnt_valid(gnt_valid), .gnt_ready(gnt_ready), .gnt_write(gnt_write),
        .gnt_data(gnt_data), .cpl_in(cpl_in), .cpl_out(cpl_out), .busy(busy)
    );

    always #10 clk = ~clk;

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 50000) begin
            fails = fails + 1;
            $display("FAIL watchdog: run hung, actual=%0d cycles expected<50000", cycles);
            finish_run();
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            fails = fails + 1;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_soft_reset();
        @(negedge clk);
        soft_rst = 1'b1;
        gnt_ready = 1'b0;
        @(negedge clk);
        soft_rst = 1'b0;
    endtask

    // One cycle of pushes; returns acceptance as seen at the ports
    task automatic push(input logic r, input logic [DW-1:0] rd, input logic w,
                        input logic [DW-1:0] wd, output logic r_acc, output logic w_acc);
        @(negedge clk);
        rd_valid = r; rd_data = rd;
        wr_valid = w; wr_data = wd;
        #1;
        r_acc = r && rd_ready;
        w_acc = w && wr_ready;
        @(negedge clk);
        rd_valid = 1'b0; wr_valid = 1'b0;
    endtask

    // Wait for a grant, check it, accept it, then complete it
    task automatic serve(input string req, input logic exp_w, input logic [DW-1:0] exp_d,
                         input logic exp_cpl, input logic exp_busy_after);
        int n = 0;
        while (!gnt_valid && n < 30) begin
            @(negedge clk);
            n++;
        end
        check({req, " grant present"}, 32'(gnt_valid), 32'd1);
        check({req, " grant type"}, 32'(gnt_write), 32'(exp_w));
        check({req, " grant data"}, 32'(gnt_data), 32'(exp_d));
        gnt_ready = 1'b1;
        @(negedge clk);
        gnt_ready = 1'b0;
        check("R10 no grant while waiting", 32'(gnt_valid), 32'd0);
        check("R8 busy while waiting", 32'(busy), 32'd1);
        cpl_in = 1'b1;
        #1;
        check("R6 completion forward", 32'(cpl_out), 32'(exp_cpl));
        @(negedge clk);
        cpl_in = 1'b0;
        check("R8 busy after retire", 32'(busy), 32'(exp_busy_after));
    endtask

    task automatic expect_no_grant(input string req, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            check(req, 32'(gnt_valid), 32'd0);
        end
    endtask

    task automatic load_pairs();
        logic a, b;
        push(1'b1, 8'h11, 1'b1, 8'hA1, a, b);
        push(1'b1, 8'h12, 1'b1, 8'hA2, a, b);
    endtask

    task automatic t_reset();
        check("R8 reset busy", 32'(busy), 32'd0);
        check("R10 reset grant", 32'(gnt_valid), 32'd0);
        check("R7 reset rd_ready", 32'(rd_ready), 32'd1);
    endtask

    task automatic t_read_first();
        do_soft_reset();
        mode = 2'b10;
        load_pairs();
        serve("R1 first", 1'b0, 8'h11, 1'b1, 1'b1);
        serve("R1 second", 1'b0, 8'h12, 1'b1, 1'b1);
        serve("R1 third", 1'b1, 8'hA1, 1'b1, 1'b1);
        serve("R1 fourth", 1'b1, 8'hA2, 1'b1, 1'b0);
    endtask

    task automatic t_write_first();
        do_soft_reset();
        mode = 2'b01;
        load_pairs();
        serve("R2 first", 1'b1, 8'hA1, 1'b1, 1'b1);
        serve("R2 second", 1'b1, 8'hA2, 1'b1, 1'b1);
        serve("R2 third", 1'b0, 8'h11, 1'b1, 1'b1);
        serve("R2 fourth", 1'b0, 8'h12, 1'b1, 1'b0);
    endtask

    task automatic t_round_robin(input logic [1:0] m);
        do_soft_reset();
        mode = m;
        load_pairs();
        serve("R3 rr first", 1'b0, 8'h11, 1'b1, 1'b1);
        serve("R3 rr second", 1'b1, 8'hA1, 1'b1, 1'b1);
        serve("R3 rr third", 1'b0, 8'h12, 1'b1, 1'b1);
        serve("R3 rr fourth", 1'b1, 8'hA2, 1'b1, 1'b0);
    endtask

    task automatic t_rr_hold();
        logic a, b;
        do_soft_reset();
        mode = 2'b00;
        push(1'b1, 8'h21, 1'b0, 8'h00, a, b);
        serve("R4 lone read", 1'b0, 8'h21, 1'b1, 1'b0);
        push(1'b1, 8'h22, 1'b1, 8'hB2, a, b);
        serve("R4 tie after lone read", 1'b0, 8'h22, 1'b1, 1'b1);
        serve("R4 then write", 1'b1, 8'hB2, 1'b1, 1'b0);
    endtask

    task automatic t_watermark_and_drop();
        logic a, b;
        int acc = 0;
        do_soft_reset();
        mode = 2'b10;
        watermark = 5'd3;
        for (int i = 0; i < 8; i++) begin
            push(1'b1, 8'h30 + 8'(i), 1'b0, 8'h00, a, b);
            if (a) acc++;
        end
        check("R7 accepted up to watermark", 32'(acc), 32'd4);
        check("R7 read ready low at mark", 32'(rd_ready), 32'd0);
        check("R7 write queue independent", 32'(wr_ready), 32'd1);
        @(negedge clk);
        enable = 1'b0;
        #1;
        check("R5 ready while disabled", 32'(rd_ready), 32'd1);
        push(1'b1, 8'hEE, 1'b1, 8'hEF, a, b);
        check("R5 drop handshake", 32'({a, b}), 32'h3);
        check("R5 in-flight grant held", 32'(gnt_data), 32'h30);
        serve("R5 in-flight completes", 1'b0, 8'h30, 1'b0, 1'b1);
        expect_no_grant("R5 no start while disabled", 5);
        check("R8 busy with queued entries", 32'(busy), 32'd1);
        enable = 1'b1;
        serve("R7 drain 1", 1'b0, 8'h31, 1'b1, 1'b1);
        serve("R7 drain 2", 1'b0, 8'h32, 1'b1, 1'b1);
        serve("R5 last kept entry", 1'b0, 8'h33, 1'b1, 1'b0);
        expect_no_grant("R5 dropped never granted", 8);
        watermark = 5'd8;
    endtask

    task automatic t_soft_reset();
        do_soft_reset();
        mode = 2'b00;
        load_pairs();
        check("R9 busy before clear", 32'(busy), 32'd1);
        do_soft_reset();
        check("R9 busy after clear", 32'(busy), 32'd0);
        check("R9 grant after clear", 32'(gnt_valid), 32'd0);
        expect_no_grant("R9 queues emptied", 8);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        enable = 1'b1;
        t_read_first();
        t_write_first();
        t_round_robin(2'b00);
        t_round_robin(2'b11);
        t_rr_hold();
        t_watermark_and_drop();
        t_soft_reset();
        finish_run();
    end

endmodule